// File: doc/BRIEF.md
# Infrared Remote Key Map Lookup

This block turns a decoded remote-control frame into a key code. It stores a small map split into groups. Each group carries a 16-bit user code as its tag and a list of pairs, where each pair maps a scan code to a key code. The map is filled through two write ports. One port sets a group's tag and its word count. The other writes the pair words themselves: the even word index holds a scan code and the odd index holds a key code.

A lookup request carries a user code and an 8-bit scan code. The block first walks the group tags, one per clock. It then walks the pairs of the first matching group, again one per clock. At the end it raises a one-cycle done pulse and reports hit or miss, the key code and a repeat count. The repeat count goes up when the same key is hit on consecutive lookups. These results stay unchanged until the next lookup finishes.

Top module: `ir_keymap`

## Requirements
- R1: After reset, busy, done and hit are 0, and key and rep are 0.
- R2: A lookup uses only the lowest-indexed group whose tag equals the requested user code. The pairs of any later group with the same tag are never searched.
- R3: Within the selected group, the lowest-indexed pair whose scan code equals the requested scan code wins. The lookup then reports hit=1 and key equal to the low 16 bits of that pair's key word. The scan code of a pair is the low 8 bits of its even word.
- R4: A group's pair count is its supplied word count divided by two, rounded down and capped at 16. Pairs at or beyond that count are never matched.
- R5: When no group tag matches, or no counted pair in the group matches, the lookup reports hit=0, key=0 and rep=0.
- R6: On a hit, rep increments if the key equals the key reported by the previous lookup. Otherwise rep becomes 0.
- R7: rep saturates at its maximum value (255) and does not wrap.
- R8: A tag write with user code 0 is ignored: the group keeps its previous tag and pair count.
- R9: busy is 1 from the cycle after an accepted request until the cycle in which done pulses. done lasts one cycle. A request made while busy is ignored and produces no result.
- R10: hit, key and rep change only in a cycle in which done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tag_we | input | 1 | Write strobe for a group's tag and word count |
| tag_grp | input | 2 | Group index for the tag write |
| tag_user | input | 16 | User code tag; 0 is rejected |
| tag_words | input | 6 | Number of 32-bit words supplied for the group |
| word_we | input | 1 | Write strobe for a pair word |
| word_grp | input | 2 | Group index for the word write |
| word_idx | input | 5 | Word index; even = scan word, odd = key word of pair idx/2 |
| word_data | input | 32 | Word value |
| req | input | 1 | Lookup request, accepted when not busy |
| req_user | input | 16 | User code to look up |
| req_scan | input | 8 | Scan code to look up |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Last lookup found a key |
| key | output | 16 | Last reported key code (0 on miss) |
| rep | output | 8 | Repeat count of the last reported key |

## Verification
The stimulus uses several lookup patterns, and each pattern separates one kind of fault:
- Two groups share a tag, and the searched scan code exists only in the later group. A miss here shows that only the first group is searched.
- A scan code appears twice in one group. The reported key shows which pair wins.
- Words are written beyond a group's pair count, and a full group is searched to its last pair. These show where the pair count bound falls.
- Runs of the same key, alternated with different keys and with misses, exercise the repeat increment and the repeat reset.
- A long run of one key checks saturation.
- A zero tag write and a request made while busy check that each is ignored.

// File: rtl/ir_keymap.sv
module ir_keymap #(
  parameter int NGRP  = 4,
  parameter int NPAIR = 16,
  parameter int KEY_W = 16,
  parameter int REP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tag_we,
  input  logic [((NGRP>1)?$clog2(NGRP):1)-1:0] tag_grp,
  input  logic [15:0]           tag_user,
  input  logic [$clog2(NPAIR)+1:0] tag_words,
  input  logic                  word_we,
  input  logic [((NGRP>1)?$clog2(NGRP):1)-1:0] word_grp,
  input  logic [$clog2(NPAIR):0] word_idx,
  input  logic [31:0]           word_data,
  input  logic                  req,
  input  logic [15:0]           req_user,
  input  logic [7:0]            req_scan,
  output logic                  busy,
  output logic                  done,
  output logic                  hit,
  output logic [KEY_W-1:0]      key,
  output logic [REP_W-1:0]      rep
);
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int PW = $clog2(NPAIR);
  localparam logic [PW:0] NP = (PW+1)'(NPAIR);
  localparam logic [REP_W-1:0] REP_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_GRP, S_PAIR} st_t;

  logic [15:0]      tag_q  [NGRP];
  logic [PW:0]      cnt_q  [NGRP];
  logic [7:0]       scan_m [NGRP][NPAIR];
  logic [KEY_W-1:0] key_m  [NGRP][NPAIR];

  st_t              st;
  logic [GW-1:0]    gi;
  logic [PW-1:0]    pi;
  logic [15:0]      user_l;
  logic [7:0]       scan_l;
  logic             fin, fhit;
  logic [KEY_W-1:0] mkey;
  logic [PW:0]      half;

  assign half = tag_words[PW+1:1];
  assign mkey = key_m[gi][pi];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGRP; g++) begin
        tag_q[g] <= '0;
        cnt_q[g] <= '0;
      end
    end else if (tag_we && tag_user != 16'd0) begin
      tag_q[tag_grp] <= tag_user;
      cnt_q[tag_grp] <= (half > NP) ? NP : half;
    end
  end

  always_ff @(posedge clk) begin
    if (word_we) begin
      if (!word_idx[0]) scan_m[word_grp][word_idx[PW:1]] <= word_data[7:0];
      else              key_m[word_grp][word_idx[PW:1]]  <= word_data[KEY_W-1:0];
    end
  end

  always_comb begin
    fin  = 1'b0;
    fhit = 1'b0;
    if (st == S_GRP) begin
      fin = !(tag_q[gi] == user_l && user_l != 16'd0) && gi == GW'(NGRP-1);
    end else if (st == S_PAIR) begin
      if ({1'b0, pi} >= cnt_q[gi])  fin = 1'b1;
      else if (scan_m[gi][pi] == scan_l) begin
        fin  = 1'b1;
        fhit = 1'b1;
      end else fin = (pi == PW'(NPAIR-1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; gi <= '0; pi <= '0; user_l <= '0; scan_l <= '0;
      busy <= 1'b0; done <= 1'b0; hit <= 1'b0; key <= '0; rep <= '0;
    end else begin
      done <= 1'b0;
      if (fin) begin
        st   <= S_IDLE;
        busy <= 1'b0;
        done <= 1'b1;
        hit  <= fhit;
        key  <= fhit ? mkey : '0;
        if (!fhit || mkey != key) rep <= '0;
        else if (rep != REP_MAX)  rep <= rep + 1'b1;
      end else begin
        case (st)
          S_IDLE: if (req) begin
            st <= S_GRP; busy <= 1'b1; gi <= '0;
            user_l <= req_user; scan_l <= req_scan;
          end
          S_GRP: begin
            if (tag_q[gi] == user_l && user_l != 16'd0) begin
              st <= S_PAIR; pi <= '0;
            end else gi <= gi + 1'b1;
          end
          S_PAIR: pi <= pi + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ir_keymap_chk.sv
module ir_keymap_chk #(
  parameter int KEY_W = 16,
  parameter int REP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             busy,
  input logic             done,
  input logic             hit,
  input logic [KEY_W-1:0] key,
  input logic [REP_W-1:0] rep
);
  localparam logic [REP_W-1:0] RMAX = '1;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (req && !busy) |=> busy); // R9
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hit) && $stable(key) && $stable(rep))); // R10
  AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> (key == '0 && rep == '0)); // R5
  AST_REP_SAME_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit && rep != '0) |-> key == $past(key)); // R6
  AST_REP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit && rep != '0) |->
      (rep == $past(rep) + 1'b1 || (rep == RMAX && $past(rep) == RMAX))); // R7
endmodule

bind ir_keymap ir_keymap_chk #(.KEY_W(KEY_W), .REP_W(REP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
  .hit(hit), .key(key), .rep(rep));

// File: tb/ir_keymap_bench.sv
`timescale 1ns/1ps
module ir_keymap_bench;
  logic clk = 0, rst_n = 0;
  logic tag_we = 0, word_we = 0, req = 0;
  logic [1:0] tag_grp = 0, word_grp = 0;
  logic [15:0] tag_user = 0, req_user = 0;
  logic [5:0] tag_words = 0;
  logic [4:0] word_idx = 0;
  logic [31:0] word_data = 0;
  logic [7:0] req_scan = 0;
  logic busy, done, hit;
  logic [15:0] key;
  logic [7:0] rep;

  always #2 clk = ~clk;

  ir_keymap u_ir_keymap (.*);

  int checks = 0, errors = 0;
  logic [15:0] m_tag [4];
  int          m_cnt [4];
  logic [7:0]  m_scan [4][16];
  logic [15:0] m_key [4][16];
  logic [15:0] e_key = 0;
  int          e_rep = 0;

  typedef struct { logic h; logic [15:0] k; int r; string tag; } exp_t;
  exp_t q[$];

  task automatic chk(bit ok, string r, string msg, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, msg, act, exp);
    end
  endtask

  task automatic load_tag(int g, logic [15:0] u, int words);
    @(negedge clk);
    tag_we = 1; tag_grp = 2'(g); tag_user = u; tag_words = 6'(words);
    @(negedge clk); tag_we = 0;
    if (u != 0) begin
      m_tag[g] = u;
      m_cnt[g] = (words / 2 > 16) ? 16 : words / 2;
    end
  endtask

  task automatic load_pair(int g, int p, logic [31:0] s, logic [31:0] k);
    @(negedge clk);
    word_we = 1; word_grp = 2'(g); word_idx = 5'(2*p); word_data = s;
    @(negedge clk);
    word_idx = 5'(2*p+1); word_data = k;
    @(negedge clk); word_we = 0;
    m_scan[g][p] = s[7:0]; m_key[g][p] = k[15:0];
  endtask

  task automatic lookup(logic [15:0] u, logic [7:0] s, string r, bit poke = 0);
    exp_t e;
    int gsel = -1;
    e.h = 0; e.k = 0; e.tag = r;
    for (int g = 0; g < 4; g++) if (gsel < 0 && m_tag[g] == u && u != 0) gsel = g;
    if (gsel >= 0)
      for (int p = 0; p < m_cnt[gsel]; p++)
        if (!e.h && m_scan[gsel][p] == s) begin e.h = 1; e.k = m_key[gsel][p]; end
    if (!e.h) e.r = 0;
    else if (e.k == e_key) e.r = (e_rep == 255) ? 255 : e_rep + 1;
    else e.r = 0;
    e_key = e.k; e_rep = e.r;
    q.push_back(e);
    @(negedge clk);
    req = 1; req_user = u; req_scan = s;
    @(negedge clk);
    req = 0;
    chk(busy == 1, "R9", "busy after request", busy, 1);
    if (poke) begin
      req = 1; req_user = 16'h00AA; req_scan = 8'h01;
      @(negedge clk); req = 0;
    end
    while (busy) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n && done) begin
    exp_t e;
    if (q.size() == 0) chk(0, "R9", "unexpected done", 1, 0);
    else begin
      e = q.pop_front();
      chk(hit == e.h, e.tag, "hit", hit, e.h);
      chk(key == e.k, e.tag, "key", key, e.k);
      chk(int'(rep) == e.r, e.tag, "rep", rep, e.r);
    end
  end

  initial begin
    #600000;
    chk(0, "R9", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int g = 0; g < 4; g++) begin m_tag[g] = 0; m_cnt[g] = 0; end
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && hit == 0, "R1", "flags after reset", {busy, done, hit}, 0);
    chk(key == 0 && rep == 0, "R1", "key/rep after reset", {key, rep}, 0);
    rst_n = 1;
    load_tag(0, 16'h1234, 6);
    load_pair(0, 0, 32'h10, 32'h0101);
    load_pair(0, 1, 32'h20, 32'h0202);
    load_pair(0, 2, 32'h10, 32'h0303);
    load_tag(1, 16'hBEEF, 40);
    for (int p = 0; p < 16; p++) load_pair(1, p, 32'(p*3), 32'(16'h1000 + p));
    load_tag(2, 16'h1234, 4);
    load_pair(2, 0, 32'h55, 32'h0777);
    load_tag(3, 16'h00AA, 3);
    load_pair(3, 0, 32'h01, 32'h0011);
    load_pair(3, 1, 32'h02, 32'h0022);
    load_tag(3, 16'h0000, 8);

    lookup(16'h1234, 8'h10, "R3");
    lookup(16'h1234, 8'h10, "R6");
    lookup(16'h1234, 8'h10, "R6");
    lookup(16'h1234, 8'h20, "R6");
    lookup(16'h1234, 8'h55, "R2");
    lookup(16'hBEEF, 8'd45, "R4");
    lookup(16'hBEEF, 8'd3, "R3");
    lookup(16'h5555, 8'h10, "R5");
    lookup(16'h00AA, 8'h01, "R8");
    lookup(16'h00AA, 8'h02, "R4");
    lookup(16'h1234, 8'h20, "R9", 1);
    repeat (5) @(negedge clk);
    chk(key == 16'h0202 && rep == 0 && hit == 1, "R10", "outputs held", {hit, key, rep}, {1'b1, 16'h0202, 8'h00});
    for (int i = 0; i < 260; i++) lookup(16'h1234, 8'h20, "R7");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9", "results outstanding", q.size(), 0);
    chk(rep == 8'd255, "R7", "saturated rep", rep, 255);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule